// File: doc/BRIEF.md
# Triggered Two-Channel DAC Register Block

This block is the register front end of a two-channel digital-to-analog converter. Software writes a 12-bit code into a per-channel holding register through a simple single-cycle read/write port. A separate output register per channel drives the converter input. How the holding value reaches the output depends on the channel's configuration. A disabled channel drives zero. An enabled channel with triggering off copies every holding write straight to its output. An enabled channel with triggering on waits for its selected trigger.

The trigger source is chosen per channel by a 4-bit code. Code 0 selects a software trigger bit. Codes 1 to 7 select one of seven timer pulse inputs, each detected on its rising edge. Codes 8 to 15 select nothing. The software trigger bits are self-clearing, so one write causes one transfer.

Each channel runs a three-state machine. The states are OFF (the output is held at zero), DIRECT (the output follows the holding register) and ARMED (the output changes only on a trigger). The next state is taken from the channel's enable and trigger-enable bits on every clock. The transitions are OFF→DIRECT (enable set, trigger enable clear) and OFF→ARMED (both set). DIRECT→ARMED sets trigger enable, and ARMED→DIRECT clears it. DIRECT→OFF and ARMED→OFF clear enable. A new configuration enters the state register on the clock edge after the control write.

Top module: `dac_trig_regs`

## Requirements
- R1: After reset both outputs are 0 and every register reads 0.
- R2: The control register sits at offset 0x00. Channel 1 uses bit 0 (enable), bit 1 (trigger enable) and bits 5:2 (trigger select). Channel 2 uses the same fields shifted up by 16 (bits 16, 17 and 21:18). All other control bits read back as 0.
- R3: Channel 1's holding register is at 0x08 and channel 2's is at 0x14. A write keeps only the low 12 bits of the data, and the register reads back zero-extended.
- R4: In DIRECT state a holding write appears on the channel output on the same clock edge that stores it.
- R5: In ARMED state a holding write leaves the output unchanged. A selected trigger copies the holding value to the output on the edge where the trigger is seen.
- R6: The software trigger register is at 0x04, with bit 0 for channel 1 and bit 1 for channel 2, and it is used by select code 0. A written bit reads 1 for one cycle, causes the transfer on the next edge and then reads 0.
- R7: Select code k in the range 1 to 7 picks timer input bit k-1. A rising edge causes exactly one transfer, and holding the input high causes no more transfers.
- R8: Select codes 8 to 15 cause no transfer from any trigger source.
- R9: In OFF state the output is 0, and software or timer triggers leave it at 0.
- R10: The output registers read at 0x2C (channel 1) and 0x30 (channel 2). Writes to those offsets change neither the outputs nor the read value.
- R11: When a holding write and a trigger fall on the same edge, the output takes the previous holding value and the holding register takes the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 6 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tmr_trig | input | 7 | Timer trigger pulse inputs, select codes 1..7 |
| dac_out1 | output | 12 | Channel 1 output register |
| dac_out2 | output | 12 | Channel 2 output register |

## Verification
A holding write and a trigger transfer can fall on the same clock edge. The bench provokes this by writing the software trigger bit and then, on the very next cycle, writing a new holding value, so the pending trigger and the write meet on one edge. It passes only if the output shows the value held before that edge and the holding register reads the new value. A second software trigger must then carry the new value across.

// File: rtl/dac_trig_pkg.sv
package dac_trig_pkg;

    typedef enum logic [1:0] {
        CH_OFF    = 2'd0,
        CH_DIRECT = 2'd1,
        CH_ARMED  = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic [3:0] tsel;
        logic       ten;
        logic       en;
    } ch_cfg_t;

    localparam int unsigned CFG_W     = 6;
    localparam int unsigned CH_STRIDE = 16;
    localparam int unsigned NUM_CH    = 2;

    localparam int unsigned OFS_CTRL   = 'h00;
    localparam int unsigned OFS_SWTRIG = 'h04;
    localparam int unsigned OFS_HOLD1  = 'h08;
    localparam int unsigned OFS_HOLD2  = 'h14;
    localparam int unsigned OFS_OUT1   = 'h2C;
    localparam int unsigned OFS_OUT2   = 'h30;

endpackage

// File: rtl/dac_edge_det.sv
module dac_edge_det #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;

    // R7: a level held high never yields two rise pulses in a row
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/dac_trig_sel.sv
module dac_trig_sel #(
    parameter int unsigned N     = 7,
    parameter int unsigned SEL_W = 4
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             sw,
    input  logic [N-1:0]     ext_rise,
    output logic             hit
);
    always_comb begin
        hit = 1'b0;
        if (sel == '0) hit = sw;
        for (int i = 0; i < N; i++) begin
            if (sel == SEL_W'(i + 1)) hit = ext_rise[i];
        end
    end
endmodule

// File: rtl/dac_chan.sv
module dac_chan
    import dac_trig_pkg::*;
#(
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ten,
    input  logic              hold_wr,
    input  logic [DATA_W-1:0] hold_wdata,
    input  logic              trig_hit,
    output logic [DATA_W-1:0] hold_q,
    output logic [DATA_W-1:0] dor_q,
    output ch_state_e         state_o
);
    ch_state_e state_q, state_d;

    always_comb begin
        if (!en)       state_d = CH_OFF;
        else if (!ten) state_d = CH_DIRECT;
        else           state_d = CH_ARMED;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       hold_q <= '0;
        else if (hold_wr) hold_q <= hold_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dor_q <= '0;
        end else begin
            unique case (state_q)
                CH_OFF:    dor_q <= '0;
                CH_DIRECT: dor_q <= hold_wr ? hold_wdata : hold_q;
                CH_ARMED:  if (trig_hit) dor_q <= hold_q;
                default:   dor_q <= '0;
            endcase
        end
    end

    assign state_o = state_q;

    assert_off_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OFF) |=> (dor_q == '0));

    assert_direct_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_DIRECT && hold_wr) |=> (dor_q == $past(hold_wdata)));

    assert_armed_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ARMED && !trig_hit) |=> $stable(dor_q));

    assert_armed_copy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ARMED && trig_hit) |=> (dor_q == $past(hold_q)));

endmodule

// File: rtl/dac_trig_regs.sv
module dac_trig_regs
    import dac_trig_pkg::*;
#(
    parameter int unsigned DATA_W  = 12,
    parameter int unsigned NUM_EXT = 7,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned BUS_W   = 32,
    parameter int unsigned SEL_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic [NUM_EXT-1:0] tmr_trig,
    output logic [DATA_W-1:0] dac_out1,
    output logic [DATA_W-1:0] dac_out2
);
    localparam int unsigned HOLD_OFS [NUM_CH] = '{OFS_HOLD1, OFS_HOLD2};
    localparam int unsigned OUT_OFS  [NUM_CH] = '{OFS_OUT1, OFS_OUT2};

    ch_cfg_t            cfg_q   [NUM_CH];
    logic [NUM_CH-1:0]  swtrig_q;
    logic [NUM_EXT-1:0] ext_rise;
    logic [DATA_W-1:0]  hold    [NUM_CH];
    logic [DATA_W-1:0]  dor     [NUM_CH];
    ch_state_e          state   [NUM_CH];
    logic [NUM_CH-1:0]  hit;

    logic wr_ctrl, wr_sw;
    assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
    assign wr_sw   = reg_wr && (reg_addr == ADDR_W'(OFS_SWTRIG));

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) swtrig_q <= '0;
        else        swtrig_q <= wr_sw ? reg_wdata[NUM_CH-1:0] : '0;
    end

    dac_edge_det #(.N(NUM_EXT)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (tmr_trig),
        .rise (ext_rise)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n)       cfg_q[c] <= '0;
            else if (wr_ctrl) cfg_q[c] <= reg_wdata[c*CH_STRIDE +: CFG_W];
        end

        dac_trig_sel #(.N(NUM_EXT), .SEL_W(SEL_W)) u_sel (
            .sel     (cfg_q[c].tsel),
            .sw      (swtrig_q[c]),
            .ext_rise(ext_rise),
            .hit     (hit[c])
        );

        dac_chan #(.DATA_W(DATA_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (cfg_q[c].en),
            .ten       (cfg_q[c].ten),
            .hold_wr   (reg_wr && (reg_addr == ADDR_W'(HOLD_OFS[c]))),
            .hold_wdata(reg_wdata[DATA_W-1:0]),
            .trig_hit  (hit[c]),
            .hold_q    (hold[c]),
            .dor_q     (dor[c]),
            .state_o   (state[c])
        );

        assert_reserved_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (state[c] == CH_ARMED && cfg_q[c].tsel > SEL_W'(NUM_EXT)) |=> $stable(dor[c]));
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_CTRL)) begin
            for (int c = 0; c < NUM_CH; c++) reg_rdata[c*CH_STRIDE +: CFG_W] = cfg_q[c];
        end
        if (reg_addr == ADDR_W'(OFS_SWTRIG)) reg_rdata[NUM_CH-1:0] = swtrig_q;
        for (int c = 0; c < NUM_CH; c++) begin
            if (reg_addr == ADDR_W'(HOLD_OFS[c])) reg_rdata[DATA_W-1:0] = hold[c];
            if (reg_addr == ADDR_W'(OUT_OFS[c]))  reg_rdata[DATA_W-1:0] = dor[c];
        end
    end

    assign dac_out1 = dor[0];
    assign dac_out2 = dor[1];

    // R6: a software trigger bit lives for one cycle unless rewritten
    assert_sw_selfclear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (swtrig_q != '0 && !wr_sw) |=> (swtrig_q == '0));

endmodule

// File: tb/dac_trig_regs_tb.sv
module dac_trig_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [6:0]  tmr_trig = '0;
    logic [11:0] dac_out1, dac_out2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dac_trig_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_trig(tmr_trig),
        .dac_out1(dac_out1), .dac_out2(dac_out2)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(input int bitn);
        tmr_trig[bitn] = 1'b1;
        @(negedge clk);
        tmr_trig[bitn] = 1'b0;
        idle(1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 out1", {20'd0, dac_out1}, 32'h0);
        chk("R1 out2", {20'd0, dac_out2}, 32'h0);
        rd(6'h00, v); chk("R1 ctrl", v, 32'h0);
        rd(6'h08, v); chk("R1 hold1", v, 32'h0);
    endtask

    task automatic t_ctrl_fields;
        logic [31:0] v;
        wr(6'h00, 32'hFFFF_FFFF);
        rd(6'h00, v); chk("R2 ctrl mask", v, 32'h003F_003F);
        wr(6'h00, 32'h0002_0025);
        rd(6'h00, v); chk("R2 ctrl fields", v, 32'h0002_0025);
        wr(6'h00, 32'h0);
        idle(2);
    endtask

    task automatic t_disabled;
        wr(6'h08, 32'hABC);
        wr(6'h04, 32'h3);
        pulse(0);
        idle(1);
        chk("R9 out1 off", {20'd0, dac_out1}, 32'h0);
        chk("R9 out2 off", {20'd0, dac_out2}, 32'h0);
    endtask

    task automatic t_hold_width;
        logic [31:0] v;
        wr(6'h08, 32'h1234_5FED);
        rd(6'h08, v); chk("R3 hold1 low12", v, 32'hFED);
        wr(6'h14, 32'h0000_FFFF);
        rd(6'h14, v); chk("R3 hold2 low12", v, 32'hFFF);
    endtask

    task automatic t_direct;
        logic [31:0] v;
        wr(6'h00, 32'h0001_0001);
        idle(2);
        chk("R4 out1 loads hold", {20'd0, dac_out1}, 32'hFED);
        wr(6'h08, 32'h123);
        chk("R4 out1 same edge", {20'd0, dac_out1}, 32'h123);
        wr(6'h2C, 32'h555);
        wr(6'h30, 32'h666);
        rd(6'h2C, v); chk("R10 out1 read", v, 32'h123);
        rd(6'h30, v); chk("R10 out2 read", v, 32'hFFF);
        chk("R10 out2 pin", {20'd0, dac_out2}, 32'hFFF);
    endtask

    task automatic t_sw_trig;
        logic [31:0] v;
        wr(6'h00, 32'h0003_0003);
        idle(2);
        wr(6'h08, 32'h111);
        idle(1);
        chk("R5 armed no change", {20'd0, dac_out1}, 32'h123);
        reg_wr = 1'b1; reg_addr = 6'h04; reg_wdata = 32'h1;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(6'h04, v); chk("R6 swtrig pending", v, 32'h1);
        @(negedge clk);
        chk("R6 out1 transferred", {20'd0, dac_out1}, 32'h111);
        rd(6'h04, v); chk("R6 swtrig cleared", v, 32'h0);
        chk("R6 out2 untouched", {20'd0, dac_out2}, 32'hFFF);
        wr(6'h14, 32'h222);
        wr(6'h04, 32'h2);
        idle(1);
        chk("R6 out2 transferred", {20'd0, dac_out2}, 32'h222);
    endtask

    task automatic t_timer;
        wr(6'h00, 32'h001F_000F);
        idle(2);
        wr(6'h08, 32'h333);
        pulse(1);
        chk("R7 wrong input", {20'd0, dac_out1}, 32'h111);
        pulse(2);
        chk("R7 code3 input2", {20'd0, dac_out1}, 32'h333);
        tmr_trig[2] = 1'b1;
        idle(1);
        wr(6'h08, 32'h444);
        idle(3);
        chk("R7 level no retrigger", {20'd0, dac_out1}, 32'h333);
        tmr_trig[2] = 1'b0;
        idle(1);
        pulse(2);
        chk("R7 second edge", {20'd0, dac_out1}, 32'h444);
        wr(6'h14, 32'h777);
        pulse(6);
        chk("R7 ch2 code7", {20'd0, dac_out2}, 32'h777);
    endtask

    task automatic t_reserved;
        wr(6'h00, 32'h0027_0027);
        idle(2);
        wr(6'h08, 32'h999);
        for (int b = 0; b < 7; b++) pulse(b);
        wr(6'h04, 32'h3);
        idle(1);
        chk("R8 reserved ch1", {20'd0, dac_out1}, 32'h444);
        chk("R8 reserved ch2", {20'd0, dac_out2}, 32'h777);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(6'h00, 32'h0000_0003);
        idle(2);
        wr(6'h08, 32'hAAA);
        wr(6'h04, 32'h1);
        wr(6'h08, 32'hBBB);
        chk("R11 out takes old", {20'd0, dac_out1}, 32'hAAA);
        rd(6'h08, v); chk("R11 hold takes new", v, 32'hBBB);
        wr(6'h04, 32'h1);
        idle(1);
        chk("R11 next trigger", {20'd0, dac_out1}, 32'hBBB);
        chk("R9 ch2 disabled", {20'd0, dac_out2}, 32'h0);
        wr(6'h00, 32'h0);
        idle(2);
        chk("R9 ch1 disabled", {20'd0, dac_out1}, 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_ctrl_fields();
        t_disabled();
        t_hold_width();
        t_direct();
        t_sw_trig();
        t_timer();
        t_reserved();
        t_collide();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule